// File: doc/BRIEF.md
# Dual-mode framed serial register loader

This block takes 16-bit words from a three-wire serial port and turns each accepted word into a register write. The three wires are a serial clock, an active-low frame sync and a data line. The block drives eight 12-bit channel registers, two 12-bit control registers and a preset command. The upper four bits of a word pick the target and the lower twelve bits carry the value. All three serial wires, and the framing-mode select, are brought into a system-clock domain through two-flop synchronisers. The system clock must run at least four times faster than the serial clock. Edges are found on the synchronised copies.

Two framing modes are supported, and the mode is held steady between frames. In controller mode, frame sync stays low for the whole word. The write is committed only when frame sync rises, and an early rise discards the word. In pulse mode, a falling edge of frame sync only starts a word, and only if the port was armed first by a serial-clock falling edge seen while frame sync was high. The word then completes on its sixteenth captured bit, whatever frame sync does.

Each committed write raises a one-cycle update strobe on every channel it touched. A preset also raises its own one-cycle strobe.

Top module: `sframe_loader`

## Requirements
- R1: A word is shifted in MSB first, one bit per serial-clock falling edge. Bits 15:12 are the target code and bits 11:0 the value. Codes 0 to 7 write channel 0 to channel 7 (A to H), and only that channel's bit of `upd_stb_o` pulses.
- R2: Code 8 writes control register 0 and code 9 writes control register 1. No channel changes and no update strobe pulses.
- R3: Code 10 clears all eight channel registers to zero. It pulses `preset_stb_o` and all eight `upd_stb_o` bits in the same cycle.
- R4: Code 11 changes no register and pulses no strobe.
- R5: Codes 12, 13, 14 and 15 write the same value into channel pairs 0/1, 2/3, 4/5 and 6/7, and pulse exactly those two strobe bits.
- R6: In controller mode (`mode_mcu_i` = 1), if frame sync rises before the sixteenth falling edge, the word is dropped with no register change and no strobe.
- R7: In controller mode, a complete word does not take effect while frame sync is still low. It takes effect after frame sync rises.
- R8: In pulse mode (`mode_mcu_i` = 0), the write takes effect after the sixteenth falling edge without any frame sync rise. Frame sync may rise early or stay low for the whole word.
- R9: In pulse mode, a frame sync falling edge that was not preceded by a serial-clock falling edge with frame sync high starts no word. The bits that follow are ignored.
- R10: In pulse mode, a frame sync falling edge inside a word that is being received neither restarts nor corrupts that word.
- R11: While reset is asserted, all registers read zero and all strobes are low.
- R12: Every strobe is high for exactly one system-clock cycle per committed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_mcu_i | input | 1 | Framing select: 1 controller mode, 0 pulse mode |
| sclk_i | input | 1 | Serial clock, asynchronous, idles high |
| fs_i | input | 1 | Frame sync, active low, asynchronous |
| din_i | input | 1 | Serial data, asynchronous |
| ch_data_o | output | 96 | Channel registers, channel i at bits [12*i+11:12*i] |
| ctrl0_o | output | 12 | Control register 0 |
| ctrl1_o | output | 12 | Control register 1 |
| upd_stb_o | output | 8 | One-cycle update strobe per channel |
| preset_stb_o | output | 1 | One-cycle preset strobe |

## Verification
Words for every target class are pushed through both framing modes, with values whose bit patterns differ between neighbouring channels. This shows whether decoding, pair writes and bit order hold in each mode. A controller-mode word is cut short to show that it is dropped. A full controller-mode word is checked once while frame sync is still low and once after it rises, which tells commit-on-rise apart from commit-on-count. Pulse-mode words are sent three ways: with frame sync held low throughout, without the arming clock edge, and with a stray frame sync pulse in the middle. Each of these distinguishes a correct start rule from a design that restarts or starts on any falling edge of frame sync.

// File: rtl/sfl_pkg.sv
`timescale 1ns/1ps
package sfl_pkg;
    localparam int unsigned CH_N   = 8;
    localparam int unsigned DATA_W = 12;
    localparam int unsigned ADDR_W = 4;

    // target codes that carry behaviour
    localparam int unsigned CODE_CTRL0  = 8;
    localparam int unsigned CODE_CTRL1  = 9;
    localparam int unsigned CODE_PRESET = 10;
    localparam int unsigned CODE_PAIR0  = 12;

    // synchroniser lane order
    localparam int unsigned LANE_SCLK = 0;
    localparam int unsigned LANE_FS   = 1;
    localparam int unsigned LANE_DIN  = 2;
    localparam int unsigned LANE_MODE = 3;
    localparam int unsigned LANES     = 4;
endpackage

// File: rtl/sfl_sync.sv
`timescale 1ns/1ps
module sfl_sync #(
    parameter int unsigned W = 4,
    parameter logic [W-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{meta: IDLE, stable: IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stable;
endmodule

// File: rtl/sfl_deframer.sv
`timescale 1ns/1ps
module sfl_deframer #(
    parameter int unsigned WORD_W = 16,
    localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mcu_i,
    input  logic              sclk_i,
    input  logic              fs_i,
    input  logic              din_i,
    output logic              vld_o,
    output logic [WORD_W-1:0] word_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic              sclk_p;
        logic              fs_p;
        logic              busy;
        logic              armed;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic              vld;
        logic [WORD_W-1:0] word;
    } dfr_st_t;

    dfr_st_t st_d, st_q;
    logic sclk_fall, fs_fall, fs_rise;

    always_comb begin
        sclk_fall = st_q.sclk_p & ~sclk_i;
        fs_fall   = st_q.fs_p & ~fs_i;
        fs_rise   = ~st_q.fs_p & fs_i;

        st_d        = st_q;
        st_d.vld    = 1'b0;
        st_d.sclk_p = sclk_i;
        st_d.fs_p   = fs_i;

        if (mcu_i) begin
            // controller framing: word lives while frame sync is low
            st_d.armed = 1'b0;
            if (st_q.busy) begin
                if (fs_rise) begin
                    st_d.busy = 1'b0;
                    if (st_q.cnt == FULL) begin
                        st_d.vld  = 1'b1;
                        st_d.word = st_q.sh;
                    end
                end else if (sclk_fall && st_q.cnt != FULL) begin
                    st_d.sh  = {st_q.sh[WORD_W-2:0], din_i};
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end else if (fs_fall) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
            end
        end else begin
            // pulse framing: start needs arming, end is by count
            if (st_q.busy) begin
                if (sclk_fall) begin
                    st_d.sh  = {st_q.sh[WORD_W-2:0], din_i};
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                    if (st_q.cnt == LAST) begin
                        st_d.busy = 1'b0;
                        st_d.vld  = 1'b1;
                        st_d.word = {st_q.sh[WORD_W-2:0], din_i};
                    end
                end
            end else if (fs_fall && st_q.armed) begin
                st_d.busy  = 1'b1;
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
            end else if (sclk_fall && fs_i) begin
                st_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.sclk_p <= 1'b1;
            st_q.fs_p   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o  = st_q.vld;
    assign word_o = st_q.word;
endmodule

// File: rtl/sfl_regfile.sv
`timescale 1ns/1ps
module sfl_regfile
    import sfl_pkg::*;
#(
    parameter int unsigned CH_NUM = CH_N,
    parameter int unsigned DW     = DATA_W,
    parameter int unsigned AW     = ADDR_W,
    localparam int unsigned WW    = AW + DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  logic [WW-1:0]        word_i,
    output logic [CH_NUM*DW-1:0] ch_o,
    output logic [DW-1:0]        ctrl0_o,
    output logic [DW-1:0]        ctrl1_o,
    output logic [CH_NUM-1:0]    upd_o,
    output logic                 preset_o
);
    typedef struct packed {
        logic [CH_NUM-1:0][DW-1:0] ch;
        logic [DW-1:0]             ctrl0;
        logic [DW-1:0]             ctrl1;
        logic [CH_NUM-1:0]         upd;
        logic                      preset;
    } rf_st_t;

    rf_st_t        st_d, st_q;
    logic [AW-1:0] code;
    logic [DW-1:0] val;

    always_comb begin
        code        = word_i[WW-1 -: AW];
        val         = word_i[DW-1:0];
        st_d        = st_q;
        st_d.upd    = '0;
        st_d.preset = 1'b0;
        if (vld_i) begin
            for (int i = 0; i < CH_NUM; i++) begin
                if (code == AW'(i) || code == AW'(CODE_PAIR0 + i / 2)) begin
                    st_d.ch[i]  = val;
                    st_d.upd[i] = 1'b1;
                end
            end
            if (code == AW'(CODE_CTRL0)) begin
                st_d.ctrl0 = val;
            end
            if (code == AW'(CODE_CTRL1)) begin
                st_d.ctrl1 = val;
            end
            if (code == AW'(CODE_PRESET)) begin
                st_d.ch     = '0;
                st_d.upd    = '1;
                st_d.preset = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ch_o     = st_q.ch;
    assign ctrl0_o  = st_q.ctrl0;
    assign ctrl1_o  = st_q.ctrl1;
    assign upd_o    = st_q.upd;
    assign preset_o = st_q.preset;
endmodule

// File: rtl/sframe_loader.sv
`timescale 1ns/1ps
module sframe_loader
    import sfl_pkg::*;
#(
    parameter int unsigned CH_NUM = CH_N,
    parameter int unsigned DW     = DATA_W,
    parameter int unsigned AW     = ADDR_W,
    localparam int unsigned WW    = AW + DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_mcu_i,
    input  logic                 sclk_i,
    input  logic                 fs_i,
    input  logic                 din_i,
    output logic [CH_NUM*DW-1:0] ch_data_o,
    output logic [DW-1:0]        ctrl0_o,
    output logic [DW-1:0]        ctrl1_o,
    output logic [CH_NUM-1:0]    upd_stb_o,
    output logic                 preset_stb_o
);
    localparam logic [LANES-1:0] IDLE_LVL =
        LANES'((1 << LANE_SCLK) | (1 << LANE_FS));

    logic [LANES-1:0] raw_lanes, syn_lanes;
    logic             frm_vld;
    logic [WW-1:0]    frm_word;

    always_comb begin
        raw_lanes            = '0;
        raw_lanes[LANE_SCLK] = sclk_i;
        raw_lanes[LANE_FS]   = fs_i;
        raw_lanes[LANE_DIN]  = din_i;
        raw_lanes[LANE_MODE] = mode_mcu_i;
    end

    sfl_sync #(.W(LANES), .IDLE(IDLE_LVL)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_lanes),
        .sync_o  (syn_lanes)
    );

    sfl_deframer #(.WORD_W(WW)) dfr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .mcu_i  (syn_lanes[LANE_MODE]),
        .sclk_i (syn_lanes[LANE_SCLK]),
        .fs_i   (syn_lanes[LANE_FS]),
        .din_i  (syn_lanes[LANE_DIN]),
        .vld_o  (frm_vld),
        .word_o (frm_word)
    );

    sfl_regfile #(.CH_NUM(CH_NUM), .DW(DW), .AW(AW)) rf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_i    (frm_vld),
        .word_i   (frm_word),
        .ch_o     (ch_data_o),
        .ctrl0_o  (ctrl0_o),
        .ctrl1_o  (ctrl1_o),
        .upd_o    (upd_stb_o),
        .preset_o (preset_stb_o)
    );
endmodule

// File: rtl/sfl_checker.sv
`timescale 1ns/1ps
module sfl_checker #(
    parameter int unsigned CH_NUM = 8,
    parameter int unsigned DW     = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frm_vld,
    input logic [CH_NUM*DW-1:0] ch_data_o,
    input logic [DW-1:0]        ctrl0_o,
    input logic [DW-1:0]        ctrl1_o,
    input logic [CH_NUM-1:0]    upd_stb_o,
    input logic                 preset_stb_o
);
    // R12
    frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |=> !frm_vld);

    // R12
    upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|upd_stb_o) |=> !(|upd_stb_o));

    // R3
    preset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset_stb_o |-> (ch_data_o == '0) && (&upd_stb_o));

    // R5
    strobe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|upd_stb_o) |-> ($countones(upd_stb_o) == 1 ||
                          $countones(upd_stb_o) == 2 ||
                          $countones(upd_stb_o) == CH_NUM));

    // R4
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|upd_stb_o) || preset_stb_o) |-> $past(frm_vld));

    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frm_vld) |-> ($stable(ctrl0_o) && $stable(ctrl1_o)));

    for (genvar g = 0; g < CH_NUM; g++) begin : g_ch
        // R1
        ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !upd_stb_o[g] |-> $stable(ch_data_o[g*DW +: DW]));
    end
endmodule

bind sframe_loader sfl_checker #(.CH_NUM(CH_NUM), .DW(DW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frm_vld      (frm_vld),
    .ch_data_o    (ch_data_o),
    .ctrl0_o      (ctrl0_o),
    .ctrl1_o      (ctrl1_o),
    .upd_stb_o    (upd_stb_o),
    .preset_stb_o (preset_stb_o)
);

// File: tb/sframe_loader_tb_top.sv
`timescale 1ns/1ps
module sframe_loader_tb_top;
    localparam int HALF = 40;    // serial half period, ns
    localparam int GAP  = 300;   // settle time after a word, ns
    localparam int NV   = 13;

    // entry: {mode_mcu, word[15:0], expected strobe mask[7:0]}
    localparam logic [24:0] VECS [NV] = '{
        {1'b1, 16'h0ABC, 8'h01},
        {1'b1, 16'h7123, 8'h80},
        {1'b0, 16'h3456, 8'h08},
        {1'b0, 16'hC5A5, 8'h03},
        {1'b1, 16'hD00F, 8'h0C},
        {1'b0, 16'hE777, 8'h30},
        {1'b1, 16'hF888, 8'hC0},
        {1'b1, 16'h8321, 8'h00},
        {1'b0, 16'h9654, 8'h00},
        {1'b1, 16'hB999, 8'h00},
        {1'b0, 16'h2FFF, 8'h04},
        {1'b1, 16'hA000, 8'hFF},
        {1'b1, 16'h1001, 8'h02}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_mcu = 1'b1;
    logic        sclk = 1'b1;
    logic        fs = 1'b1;
    logic        din = 1'b0;
    logic [95:0] ch_data;
    logic [11:0] ctrl0, ctrl1;
    logic [7:0]  upd_stb;
    logic        preset_stb;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int stb_cnt [8];
    int pulse_cyc = 0;
    int pre_cnt = 0;
    int snap_cnt [8];
    int snap_pulse = 0;
    int snap_pre = 0;

    logic [11:0] m_ch [8];
    logic [11:0] m_c0, m_c1;

    always #5 clk = ~clk;   // 100 MHz

    sframe_loader dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_mcu_i   (mode_mcu),
        .sclk_i       (sclk),
        .fs_i         (fs),
        .din_i        (din),
        .ch_data_o    (ch_data),
        .ctrl0_o      (ctrl0),
        .ctrl1_o      (ctrl1),
        .upd_stb_o    (upd_stb),
        .preset_stb_o (preset_stb)
    );

    initial begin
        for (int i = 0; i < 8; i++) stb_cnt[i] = 0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (|upd_stb) pulse_cyc++;
            if (preset_stb) pre_cnt++;
            for (int i = 0; i < 8; i++) if (upd_stb[i]) stb_cnt[i]++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic snap();
        for (int i = 0; i < 8; i++) snap_cnt[i] = stb_cnt[i];
        snap_pulse = pulse_cyc;
        snap_pre = pre_cnt;
    endtask

    task automatic model_apply(input logic [15:0] w);
        logic [3:0]  a;
        logic [11:0] v;
        a = w[15:12];
        v = w[11:0];
        if (a < 4'd8) m_ch[a[2:0]] = v;
        else if (a == 4'd8) m_c0 = v;
        else if (a == 4'd9) m_c1 = v;
        else if (a == 4'd10) for (int i = 0; i < 8; i++) m_ch[i] = 12'h000;
        else if (a >= 4'd12) begin
            m_ch[2 * (a - 4'd12)]     = v;
            m_ch[2 * (a - 4'd12) + 1] = v;
        end
    endtask

    task automatic verify(input string req, input logic [7:0] exp_mask,
                          input int exp_pre);
        logic [7:0] mask;
        for (int i = 0; i < 8; i++) mask[i] = (stb_cnt[i] != snap_cnt[i]);
        check(mask == exp_mask, req, 32'(mask), 32'(exp_mask));
        // R12: one strobe cycle per committed write
        check((pulse_cyc - snap_pulse) == ((exp_mask != 0) ? 1 : 0), req,
              32'(pulse_cyc - snap_pulse), (exp_mask != 0) ? 1 : 0);
        check((pre_cnt - snap_pre) == exp_pre, req, 32'(pre_cnt - snap_pre),
              32'(exp_pre));
        for (int i = 0; i < 8; i++)
            check(ch_data[i*12 +: 12] == m_ch[i], req, 32'(ch_data[i*12 +: 12]),
                  32'(m_ch[i]));
        check(ctrl0 == m_c0, req, 32'(ctrl0), 32'(m_c0));
        check(ctrl1 == m_c1, req, 32'(ctrl1), 32'(m_c1));
    endtask

    task automatic mcu_frame(input logic [15:0] w, input int nbits, input bit raise);
        mode_mcu = 1'b1;
        #(HALF);
        fs = 1'b0;
        #(HALF);
        for (int i = 0; i < nbits; i++) begin
            din = w[15 - i];
            #(HALF) sclk = 1'b0;
            #(HALF) sclk = 1'b1;
        end
        #(HALF);
        if (raise) fs = 1'b1;
        #(GAP);
    endtask

    // fs_bits: bit index at which frame sync returns high (>=16 keeps it low)
    task automatic dsp_frame(input logic [15:0] w, input bit arm, input int fs_bits,
                             input bit stray);
        mode_mcu = 1'b0;
        #(HALF);
        if (arm) begin
            #(HALF) sclk = 1'b0;
            #(HALF) sclk = 1'b1;
        end
        #(HALF) fs = 1'b0;
        for (int i = 0; i < 16; i++) begin
            din = w[15 - i];
            if (i == fs_bits) fs = 1'b1;
            if (stray && i == 8) fs = 1'b0;
            if (stray && i == 9) fs = 1'b1;
            #(HALF) sclk = 1'b0;
            #(HALF) sclk = 1'b1;
        end
        #(GAP);
    endtask

    initial begin
        #(1_000_000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        string tag;
        logic [15:0] w;
        for (int i = 0; i < 8; i++) m_ch[i] = 12'h000;
        m_c0 = 12'h000;
        m_c1 = 12'h000;
        #3;
        #(100);
        // R11: reset state
        check(ch_data == '0, "R11", 32'(ch_data[31:0]), 0);
        check(ctrl0 == 0 && ctrl1 == 0, "R11", 32'({ctrl0, ctrl1}), 0);
        check(upd_stb == 0 && preset_stb == 0, "R11", 32'({upd_stb, preset_stb}), 0);
        rst_n = 1'b1;
        #(100);

        for (int v = 0; v < NV; v++) begin
            w = VECS[v][23:8];
            if (w[15:12] < 4'd8) tag = "R1";
            else if (w[15:12] < 4'd10) tag = "R2";
            else if (w[15:12] == 4'd10) tag = "R3";
            else if (w[15:12] == 4'd11) tag = "R4";
            else tag = "R5";
            snap();
            if (VECS[v][24]) mcu_frame(w, 16, 1'b1);
            else dsp_frame(w, 1'b1, 1, 1'b0);
            model_apply(w);
            verify(tag, VECS[v][7:0], (w[15:12] == 4'd10) ? 1 : 0);
        end

        // R6: controller word cut short after ten bits
        snap();
        mcu_frame(16'h0555, 10, 1'b1);
        verify("R6", 8'h00, 0);

        // R7: full word, frame sync still low -> nothing yet
        snap();
        mcu_frame(16'h1ABC, 16, 1'b0);
        verify("R7", 8'h00, 0);
        fs = 1'b1;
        #(GAP);
        model_apply(16'h1ABC);
        verify("R7", 8'h02, 0);

        // R8: pulse mode, frame sync low for the whole word
        snap();
        dsp_frame(16'h6DEF, 1'b1, 99, 1'b0);
        model_apply(16'h6DEF);
        verify("R8", 8'h40, 0);
        fs = 1'b1;
        #(GAP);

        // R9: no arming edge before frame sync falls
        snap();
        dsp_frame(16'h5111, 1'b0, 99, 1'b0);
        fs = 1'b1;
        #(GAP);
        verify("R9", 8'h00, 0);

        // R10: stray frame sync pulse in the middle of a word
        snap();
        dsp_frame(16'h4321, 1'b1, 2, 1'b1);
        model_apply(16'h4321);
        verify("R10", 8'h10, 0);

        // R11: reset clears a loaded state
        rst_n = 1'b0;
        #(50);
        check(ch_data == '0, "R11", 32'(ch_data[31:0]), 0);
        check(ctrl0 == 0 && ctrl1 == 0, "R11", 32'({ctrl0, ctrl1}), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule